// File: doc/BRIEF.md
# Shadow-Access DMA Start Detector

This block sits on the load/store path of a processor and looks only at accesses that land in a dedicated shadow address window. A user process asks for a DMA transfer by issuing five accesses to that window. The order is store, load, store, load, load. The three stores and the final load all target one shadow address, which names the destination. The two middle loads target a second shadow address, which names the source. Each store carries the transfer size as its write data.

The detector tracks how far a sequence has progressed. Any access that does not fit the next position clears that progress, so accesses from another process that interleave with a sequence cannot produce a transfer. When the fifth access completes a valid sequence and the data mover is idle, the detector raises a one-cycle start pulse. The pulse carries the source offset, the destination offset and the size. Every load returns a status word, so the issuing process learns whether its transfer was started.

Top module: `shadow_dma_trigger`

## Requirements
- R1: An access is examined only if `acc_valid` is high and the upper address bits (above bit `WIN_LOG2`) equal those of `WIN_BASE`. Any other access leaves the tracker's progress unchanged, returns 0 on `acc_rdata`, and never raises `start_pulse`.
- R2: A start is produced by five in-window accesses in the order store, load, store, load, load. `acc_write` is 1 for a store and 0 for a load.
- R3: Accesses 1, 3 and 5 must use one shadow address (the destination), and accesses 2 and 4 must use one shadow address (the source). A mismatch at any of these positions produces no start.
- R4: The write data of store 1 is the transfer size. Store 3 must carry the same value, or the sequence is abandoned.
- R5: An in-window access that fails its position is evaluated again as a first access. A failing store therefore opens a new sequence at once, and a failing load leaves the tracker empty.
- R6: A load returns status 0 while a sequence is incomplete. The completing load returns 1 if the transfer starts and 2 if the mover is busy. Stores return 0.
- R7: `start_pulse` is high for exactly one cycle, in the same cycle as the fifth access. `start_src` and `start_dst` are the shadow addresses minus `WIN_BASE`, and `start_size` is the size from store 1.
- R8: While `mover_busy` is high, a completed sequence does not raise `start_pulse`. Its final load returns 2, and the tracker returns to empty.
- R9: When another process's accesses break in part-way through a sequence, the interleaved result raises no start.
- R10: After reset the tracker is empty and `start_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | DATA_W | Store data (transfer size) |
| mover_busy | input | 1 | Data mover still running a previous transfer |
| acc_rdata | output | DATA_W | Status word returned to loads |
| start_pulse | output | 1 | One-cycle transfer start |
| start_src | output | WIN_LOG2 | Source offset inside the window |
| start_dst | output | WIN_LOG2 | Destination offset inside the window |
| start_size | output | DATA_W | Transfer size |

## Verification
The hardest situation to reach is a sequence that is almost valid and broken at just one position. Typical cases are a foreign store that lands between the first load and the second store, or a second store whose size differs by one. These cases show that the tracker re-evaluates the failing access instead of simply discarding it. The directed tasks build such sequences access by access, with interleavings modelled on two competing processes. They check that no pulse appears and that the status words stay 0. They then issue a clean sequence, which proves the tracker recovered. A separate task holds the busy input high across a full sequence to reach status 2.

// File: rtl/sdt_pkg.sv
// Shared types for the shadow-access DMA start detector.
// Assumes: status words fit in the low bits of the read data bus.
package sdt_pkg;

    // Which access the tracker expects next.
    typedef enum logic [2:0] {
        AWAIT_ST1 = 3'd0,
        AWAIT_LD2 = 3'd1,
        AWAIT_ST3 = 3'd2,
        AWAIT_LD4 = 3'd3,
        AWAIT_LD5 = 3'd4
    } trk_state_t;

    localparam int STAT_PENDING = 0;
    localparam int STAT_STARTED = 1;
    localparam int STAT_BUSY    = 2;

endpackage

// File: rtl/sdt_window_decode.sv
// Window decoder: flags accesses inside the shadow window and strips the base.
// Assumes: the window is 2**WIN_LOG2 bytes and WIN_BASE is aligned to that size.
module sdt_window_decode #(
    parameter int                ADDR_W   = 32,
    parameter int                WIN_LOG2 = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000
) (
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    output logic                hit,
    output logic [WIN_LOG2-1:0] offset
);

    // Compare the upper address bits against the window base.
    always_comb begin
        hit    = acc_valid && (acc_addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
        offset = acc_addr[WIN_LOG2-1:0];
    end

endmodule

// File: rtl/sdt_seq_tracker.sv
// Sequence tracker: follows the store/load/store/load/load pattern and checks
// the repeated destination, source and size. On a mismatch it re-evaluates the
// failing access as a possible first access.
// Assumes: at most one access per cycle and hit already qualified by valid.
module sdt_seq_tracker
    import sdt_pkg::*;
#(
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              is_write,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic              seq_done,
    output logic [OFF_W-1:0]  src_off,
    output logic [OFF_W-1:0]  dst_off,
    output logic [DATA_W-1:0] size
);

    trk_state_t        state_q, state_n;
    logic [OFF_W-1:0]  dst_q, dst_n, src_q, src_n;
    logic [DATA_W-1:0] size_q, size_n;
    logic              restart;

    // Next-state decision for the current access.
    always_comb begin
        state_n  = state_q;
        dst_n    = dst_q;
        src_n    = src_q;
        size_n   = size_q;
        restart  = 1'b0;
        seq_done = 1'b0;
        if (hit) begin
            case (state_q)
                AWAIT_ST1: restart = 1'b1;
                AWAIT_LD2: begin
                    if (!is_write) begin
                        src_n   = offset;
                        state_n = AWAIT_ST3;
                    end else begin
                        restart = 1'b1;
                    end
                end
                AWAIT_ST3: begin
                    if (is_write && offset == dst_q && wdata == size_q)
                        state_n = AWAIT_LD4;
                    else
                        restart = 1'b1;
                end
                AWAIT_LD4: begin
                    if (!is_write && offset == src_q)
                        state_n = AWAIT_LD5;
                    else
                        restart = 1'b1;
                end
                AWAIT_LD5: begin
                    if (!is_write && offset == dst_q) begin
                        seq_done = 1'b1;
                        state_n  = AWAIT_ST1;
                    end else begin
                        restart = 1'b1;
                    end
                end
                default: restart = 1'b1;
            endcase
            if (restart) begin
                if (is_write) begin
                    dst_n   = offset;
                    size_n  = wdata;
                    state_n = AWAIT_LD2;
                end else begin
                    state_n = AWAIT_ST1;
                end
            end
        end
    end

    // Register progress and the captured arguments.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AWAIT_ST1;
            dst_q   <= '0;
            src_q   <= '0;
            size_q  <= '0;
        end else begin
            state_q <= state_n;
            dst_q   <= dst_n;
            src_q   <= src_n;
            size_q  <= size_n;
        end
    end

    // Present captured arguments to the start logic.
    always_comb begin
        src_off = src_q;
        dst_off = dst_q;
        size    = size_q;
    end

    // R1: accesses outside the window do not move the tracker.
    a_r1_outside_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(state_q));

    // R5: an in-window store seen while empty opens a sequence.
    a_r5_store_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && is_write && state_q == AWAIT_ST1) |=> state_q == AWAIT_LD2);

    // R2: completion happens only on a load.
    a_r2_done_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (hit && !is_write));

endmodule

// File: rtl/sdt_status_gen.sv
// Status and start generator: turns a completed sequence into a start pulse
// when the mover is idle and builds the status word returned to loads.
// Assumes: seq_done is only high during an in-window load.
module sdt_status_gen
    import sdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              hit,
    input  logic              is_write,
    input  logic              seq_done,
    input  logic              mover_busy,
    output logic              start,
    output logic [DATA_W-1:0] rdata
);

    // Choose start and the status word for the current access.
    always_comb begin
        start = seq_done && !mover_busy;
        rdata = '0;
        if (hit && !is_write) begin
            if (seq_done)
                rdata = mover_busy ? DATA_W'(STAT_BUSY) : DATA_W'(STAT_STARTED);
            else
                rdata = DATA_W'(STAT_PENDING);
        end
    end

endmodule

// File: rtl/shadow_dma_trigger.sv
// Shadow-access DMA start detector top: decodes the shadow window, tracks the
// five-access command sequence and issues a one-cycle start.
// Assumes: one access per cycle; outputs are combinational from the access.
module shadow_dma_trigger #(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter int                WIN_LOG2 = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [DATA_W-1:0]   acc_wdata,
    input  logic                mover_busy,
    output logic [DATA_W-1:0]   acc_rdata,
    output logic                start_pulse,
    output logic [WIN_LOG2-1:0] start_src,
    output logic [WIN_LOG2-1:0] start_dst,
    output logic [DATA_W-1:0]   start_size
);

    logic                hit;
    logic [WIN_LOG2-1:0] offset;
    logic                seq_done;
    logic [WIN_LOG2-1:0] src_off, dst_off;
    logic [DATA_W-1:0]   size;

    sdt_window_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_LOG2(WIN_LOG2),
        .WIN_BASE(WIN_BASE)
    ) u_dec (
        .acc_valid(acc_valid),
        .acc_addr (acc_addr),
        .hit      (hit),
        .offset   (offset)
    );

    sdt_seq_tracker #(
        .OFF_W (WIN_LOG2),
        .DATA_W(DATA_W)
    ) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .is_write(acc_write),
        .offset  (offset),
        .wdata   (acc_wdata),
        .seq_done(seq_done),
        .src_off (src_off),
        .dst_off (dst_off),
        .size    (size)
    );

    sdt_status_gen #(
        .DATA_W(DATA_W)
    ) u_stat (
        .hit       (hit),
        .is_write  (acc_write),
        .seq_done  (seq_done),
        .mover_busy(mover_busy),
        .start     (start_pulse),
        .rdata     (acc_rdata)
    );

    // Drive start arguments: the final load's address is the destination.
    always_comb begin
        start_src  = src_off;
        start_dst  = dst_off;
        start_size = size;
    end

    // R7: the pulse never lasts two cycles.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    // R7: the pulse coincides with a load access.
    a_r7_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (acc_valid && !acc_write));

    // R6: a started transfer reports status 1 to the issuing load.
    a_r6_started_status: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> acc_rdata == DATA_W'(1));

    // R8: no start while the mover is busy.
    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mover_busy |-> !start_pulse);

endmodule

// File: tb/shadow_dma_trigger_test.sv
// Directed bench for the shadow-access DMA start detector.
module shadow_dma_trigger_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        mover_busy = 1'b0;
    logic [31:0] acc_rdata;
    logic        start_pulse;
    logic [11:0] start_src, start_dst;
    logic [31:0] start_size;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [31:0] BASE = 32'h8000_0000;
    localparam logic [31:0] DST  = BASE + 32'h100;
    localparam logic [31:0] DST2 = BASE + 32'h200;
    localparam logic [31:0] SRC  = BASE + 32'h040;
    localparam logic [31:0] SRC2 = BASE + 32'h080;
    localparam logic [31:0] OUTA = 32'h1000_0100;

    logic [11:0] e_src, e_dst;
    logic [31:0] e_size;

    always #2 clk = ~clk;

    shadow_dma_trigger uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .mover_busy(mover_busy),
        .acc_rdata(acc_rdata), .start_pulse(start_pulse), .start_src(start_src),
        .start_dst(start_dst), .start_size(start_size)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access; checks status word and start outputs before the edge.
    task automatic acc(input bit w, input logic [31:0] a, input logic [31:0] d,
                       input int exp_rd, input bit exp_st, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
        #1;
        chk(acc_rdata == 32'(exp_rd), {tag, " rdata"}, acc_rdata, 32'(exp_rd));
        chk(start_pulse == exp_st, {tag, " start"}, 32'(start_pulse), 32'(exp_st));
        if (exp_st) begin
            chk(start_src == e_src, {tag, " src"}, 32'(start_src), 32'(e_src));
            chk(start_dst == e_dst, {tag, " dst"}, 32'(start_dst), 32'(e_dst));
            chk(start_size == e_size, {tag, " size"}, start_size, e_size);
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        #1;
        chk(start_pulse == 1'b0, "R7 idle no pulse", 32'(start_pulse), 0);
        @(posedge clk);
    endtask

    // Clean five-access sequence; last load expects status st.
    task automatic full_seq(input logic [31:0] dst, input logic [31:0] src,
                            input logic [31:0] sz, input int st, input string tag);
        e_dst = dst[11:0]; e_src = src[11:0]; e_size = sz;
        acc(1, dst, sz, 0, 0, tag);
        acc(0, src, 0, 0, 0, tag);
        acc(1, dst, sz, 0, 0, tag);
        acc(0, src, 0, 0, 0, tag);
        acc(0, dst, 0, st, st == 1, tag);
        idle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(start_pulse == 1'b0, "R10 reset start", 32'(start_pulse), 0);
        chk(acc_rdata == 0, "R10 reset rdata", acc_rdata, 0);
        acc(0, DST, 0, 0, 0, "R10 lone load after reset");
    endtask

    task automatic t_basic();
        full_seq(DST, SRC, 32'd64, 1, "R2 R7 basic");
        full_seq(DST2, SRC2, 32'd4096, 1, "R3 R7 second pair");
    endtask

    task automatic t_window();
        e_dst = 12'h100; e_src = 12'h040; e_size = 32'd9;
        acc(1, DST, 9, 0, 0, "R1 s1");
        acc(0, OUTA, 0, 0, 0, "R1 outside load");
        acc(0, SRC, 0, 0, 0, "R1 l2");
        acc(1, OUTA, 5, 0, 0, "R1 outside store");
        acc(1, DST, 9, 0, 0, "R1 s3");
        acc(0, SRC, 0, 0, 0, "R1 l4");
        acc(0, OUTA + 32'h2000, 0, 0, 0, "R1 outside load 2");
        acc(0, DST, 0, 1, 1, "R1 completes across outside accesses");
        idle();
    endtask

    task automatic t_addr();
        acc(1, DST, 8, 0, 0, "R3 dst mm");
        acc(0, SRC, 0, 0, 0, "R3 dst mm");
        acc(1, DST2, 8, 0, 0, "R3 dst mm");
        acc(0, SRC, 0, 0, 0, "R3 dst mm");
        acc(0, DST, 0, 0, 0, "R3 wrong dst no start");
        acc(1, DST, 8, 0, 0, "R3 src mm");
        acc(0, SRC, 0, 0, 0, "R3 src mm");
        acc(1, DST, 8, 0, 0, "R3 src mm");
        acc(0, SRC2, 0, 0, 0, "R3 src mm");
        acc(0, DST, 0, 0, 0, "R3 wrong src no start");
        acc(1, DST, 8, 0, 0, "R3 fifth mm");
        acc(0, SRC, 0, 0, 0, "R3 fifth mm");
        acc(1, DST, 8, 0, 0, "R3 fifth mm");
        acc(0, SRC, 0, 0, 0, "R3 fifth mm");
        acc(0, DST2, 0, 0, 0, "R3 wrong fifth addr no start");
        idle();
    endtask

    task automatic t_size();
        acc(1, DST, 64, 0, 0, "R4 size");
        acc(0, SRC, 0, 0, 0, "R4 size");
        acc(1, DST, 65, 0, 0, "R4 size");
        acc(0, SRC, 0, 0, 0, "R4 size");
        acc(0, DST, 0, 0, 0, "R4 size mismatch no start");
        idle();
    endtask

    task automatic t_restart();
        e_dst = 12'h100; e_src = 12'h040; e_size = 32'd32;
        acc(1, DST2, 7, 0, 0, "R5 stray store");
        acc(1, DST, 32, 0, 0, "R5 store reopens");
        acc(0, SRC, 0, 0, 0, "R5");
        acc(1, DST, 32, 0, 0, "R5");
        acc(0, SRC, 0, 0, 0, "R5");
        acc(0, DST, 0, 1, 1, "R5 restarted sequence starts");
        acc(0, SRC, 0, 0, 0, "R5 load while empty");
        acc(1, DST, 32, 0, 0, "R5 wrong type");
        acc(0, SRC, 0, 0, 0, "R5 wrong type");
        acc(0, SRC, 0, 0, 0, "R5 load in store slot");
        acc(0, DST, 0, 0, 0, "R5 load in store slot no start");
        idle();
        full_seq(DST, SRC, 32'd32, 1, "R5 recovers");
    endtask

    task automatic t_interleave();
        acc(1, DST, 16, 0, 0, "R9 procA s1");
        acc(0, SRC, 0, 0, 0, "R9 procA l2");
        acc(1, DST2, 99, 0, 0, "R9 procB store");
        acc(1, DST, 16, 0, 0, "R9 procA s3");
        acc(0, SRC, 0, 0, 0, "R9 procA l4");
        acc(0, DST, 0, 0, 0, "R9 interleaved no start");
        idle();
        acc(1, DST, 16, 0, 0, "R9 legit s1");
        acc(0, SRC, 0, 0, 0, "R9 legit l2");
        acc(1, DST, 16, 0, 0, "R9 legit s3");
        acc(0, SRC2, 0, 0, 0, "R9 procB load");
        acc(0, SRC, 0, 0, 0, "R9 legit l4");
        acc(0, DST, 0, 0, 0, "R9 interleaved load no start");
        idle();
    endtask

    task automatic t_busy();
        mover_busy = 1'b1;
        full_seq(DST, SRC, 32'd128, 2, "R8 busy");
        mover_busy = 1'b0;
        acc(0, DST, 0, 0, 0, "R8 tracker empty after busy");
        idle();
        full_seq(DST, SRC, 32'd128, 1, "R8 after busy");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_window();
        t_addr();
        t_size();
        t_restart();
        t_interleave();
        t_busy();
        finish_run();
    end

endmodule